// File: doc/BRIEF.md
# Two-Part Long Call Sequencer

This block carries out a long subroutine call of the compact 16-bit instruction encoding. In that encoding the call is split across two halfwords that execute one after the other. The first halfword, the upper part, adds a signed, shifted offset to the current program counter and parks the partial target in the link register. The second halfword, the finish part, adds a small unsigned offset to that parked value. It then writes the result to the program counter and replaces the link register with the return address. The finish part comes in two forms. The keep form stays in compact state. The switch form clears the state bit and lands in the 32-bit encoding. The switch form exists only on the core variant that supports it; on the other variant it does nothing.

Each halfword is presented as its own single-cycle operation with a valid strobe. The block keeps no state of its own between the two parts: the parked value travels through the register file and comes back on `in_link`. Results are registered and leave the block as write-enable and data pairs for the link register and the program counter, plus a strobe that clears the state bit.

Top module: `lbs_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output (`lr_we`, `lr_wdata`, `pc_we`, `pc_wdata`, `state_clr`) is zero after that edge.
- R2: An upper part (`in_kind` = 2'b01) writes the link register with `in_pc` plus the 11-bit field, taken as a signed number and multiplied by 4096. It does not write the program counter and does not pulse `state_clr`.
- R3: A keep finish (`in_kind` = 2'b10) writes the program counter with ((`in_link` + 2·field) with bit 0 cleared) + 2. It writes the link register with `in_pc` − 1 and leaves the state bit alone. The variant flag has no effect on it.
- R4: A switch finish (`in_kind` = 2'b11) with `in_switch_ok` high writes the program counter with ((`in_link` + 2·field) with bits 1:0 cleared) + 4. It writes the link register with `in_pc` − 1 and pulses `state_clr`.
- R5: A switch finish with `in_switch_ok` low makes no write of any kind.
- R6: The finish field is zero-extended, so a field with its top bit set moves the target forward by up to 4094 bytes. The new program counter is formed from the incoming link value and not from the return address.
- R7: A cycle with `in_valid` low, or with `in_kind` = 2'b00, makes no write.
- R8: Every result appears in the cycle after the edge that samples its request and lasts one cycle. Requests on consecutive cycles each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe for one halfword |
| in_kind | input | 2 | 00 none, 01 upper part, 10 keep finish, 11 switch finish |
| in_field | input | OFF_W (11) | Offset field of the halfword |
| in_pc | input | ADDR_W (32) | Current program counter value |
| in_link | input | ADDR_W (32) | Current link register value |
| in_switch_ok | input | 1 | High on the core variant that supports the switch finish |
| lr_we | output | 1 | Link register write enable |
| lr_wdata | output | ADDR_W (32) | Link register write value |
| pc_we | output | 1 | Program counter write enable |
| pc_wdata | output | ADDR_W (32) | Program counter write value |
| state_clr | output | 1 | Clear the compact-state bit |

## Verification
Every output is one register stage behind its request. A request that is sampled at one rising edge is therefore visible from that edge until the next one. The bench drives each request on a falling edge and reads the outputs on the following falling edge, exactly one sampling edge later. When requests run back to back, each result is read before the next request is driven. For the two-part sequences, the link value read after the upper part is fed back as `in_link` for the finish part. The final program counter is then checked against hand-computed values at both ends of the ±4 MiB reach.

// File: rtl/lbs_pkg.sv
// Package: shared request classes for the long call sequencer.
// Assumes the class arrives already decoded on a 2-bit field.
package lbs_pkg;
    typedef enum logic [1:0] {
        LBS_NONE   = 2'b00,
        LBS_UPPER  = 2'b01,
        LBS_KEEP   = 2'b10,
        LBS_SWITCH = 2'b11
    } lbs_kind_e;
endpackage

// File: rtl/lbs_offset.sv
// Module: turns the halfword offset field into the two addends.
// Upper addend: the field doubled, sign-extended, then shifted by OFF_W more bits.
// Finish addend: the field doubled and zero-extended.
// Assumes ADDR_W > OFF_W + 1.
module lbs_offset #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 11
) (
    input  logic [OFF_W-1:0]  field,
    output logic [ADDR_W-1:0] upper_add,
    output logic [ADDR_W-1:0] finish_add
);
    localparam int DBL_W = OFF_W + 1;
    localparam int PAD_W = ADDR_W - DBL_W;

    logic [DBL_W-1:0]  dbl;
    logic [ADDR_W-1:0] dbl_sext;

    // Double the field and extend it both ways.
    always_comb begin
        dbl        = {field, 1'b0};
        dbl_sext   = {{PAD_W{dbl[DBL_W-1]}}, dbl};
        upper_add  = dbl_sext << OFF_W;
        finish_add = {{PAD_W{1'b0}}, dbl};
    end
endmodule

// File: rtl/lbs_target.sv
// Module: forms the finish target from the parked link value.
// Keep form: clear bit 0, add 2. Switch form: clear bits 1:0, add 4.
// Assumes link_in is the value before any return-address write.
module lbs_target #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] link_in,
    input  logic [ADDR_W-1:0] add_in,
    input  logic              word_mode,
    output logic [ADDR_W-1:0] target
);
    localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);

    logic [ADDR_W-1:0] sum;

    // Add the offset, align for the destination state, apply the step.
    always_comb begin
        sum = link_in + add_in;
        if (word_mode) begin
            target = {sum[ADDR_W-1:2], 2'b00} + STEP_WORD;
        end else begin
            target = {sum[ADDR_W-1:1], 1'b0} + STEP_HALF;
        end
    end
endmodule

// File: rtl/lbs_outreg.sv
// Module: one register stage with synchronous active-low clear.
// Assumes the whole result bundle moves together.
module lbs_outreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the bundle, or clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lbs_seq.sv
// Module: two-part long call sequencer, top level.
// Each halfword is a separate one-cycle request; no state is held
// between the parts, the partial target comes back on in_link.
// Results leave one cycle after the sampling edge. Data outputs are
// zero in cycles without a write.
module lbs_seq #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [OFF_W-1:0]  in_field,
    input  logic [ADDR_W-1:0] in_pc,
    input  logic [ADDR_W-1:0] in_link,
    input  logic              in_switch_ok,
    output logic              lr_we,
    output logic [ADDR_W-1:0] lr_wdata,
    output logic              pc_we,
    output logic [ADDR_W-1:0] pc_wdata,
    output logic              state_clr
);
    import lbs_pkg::*;

    localparam int                BUNDLE_W = 3 + 2 * ADDR_W;
    localparam logic [ADDR_W-1:0] RET_STEP = ADDR_W'(1);

    lbs_kind_e         kind;
    logic [ADDR_W-1:0] upper_add;
    logic [ADDR_W-1:0] finish_add;
    logic [ADDR_W-1:0] finish_pc;
    logic              lr_we_d;
    logic              pc_we_d;
    logic              clr_d;
    logic [ADDR_W-1:0] lr_d;
    logic [ADDR_W-1:0] pc_d;
    logic [BUNDLE_W-1:0] bundle_d;
    logic [BUNDLE_W-1:0] bundle_q;

    // Name the request class.
    always_comb kind = lbs_kind_e'(in_kind);

    lbs_offset #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_offset (
        .field      (in_field),
        .upper_add  (upper_add),
        .finish_add (finish_add)
    );

    lbs_target #(.ADDR_W(ADDR_W)) u_target (
        .link_in   (in_link),
        .add_in    (finish_add),
        .word_mode (kind == LBS_SWITCH),
        .target    (finish_pc)
    );

    // Choose the writes for this request.
    always_comb begin
        lr_we_d = 1'b0;
        pc_we_d = 1'b0;
        clr_d   = 1'b0;
        lr_d    = '0;
        pc_d    = '0;
        if (in_valid) begin
            unique case (kind)
                LBS_UPPER: begin
                    lr_we_d = 1'b1;
                    lr_d    = in_pc + upper_add;
                end
                LBS_KEEP: begin
                    lr_we_d = 1'b1;
                    lr_d    = in_pc - RET_STEP;
                    pc_we_d = 1'b1;
                    pc_d    = finish_pc;
                end
                LBS_SWITCH: begin
                    if (in_switch_ok) begin
                        lr_we_d = 1'b1;
                        lr_d    = in_pc - RET_STEP;
                        pc_we_d = 1'b1;
                        pc_d    = finish_pc;
                        clr_d   = 1'b1;
                    end
                end
                default: begin
                    lr_we_d = 1'b0;
                end
            endcase
        end
    end

    // Pack the results for the register stage.
    always_comb bundle_d = {lr_we_d, pc_we_d, clr_d, lr_d, pc_d};

    lbs_outreg #(.W(BUNDLE_W)) u_outreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bundle_d),
        .q     (bundle_q)
    );

    // Unpack the registered results onto the ports.
    always_comb begin
        lr_we     = bundle_q[BUNDLE_W-1];
        pc_we     = bundle_q[BUNDLE_W-2];
        state_clr = bundle_q[BUNDLE_W-3];
        lr_wdata  = bundle_q[2*ADDR_W-1:ADDR_W];
        pc_wdata  = bundle_q[ADDR_W-1:0];
    end
endmodule

// File: rtl/lbs_seq_chk.sv
// Module: property checker for lbs_seq, attached by bind.
// Assumes one register stage between request and result.
module lbs_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_kind,
    input logic [ADDR_W-1:0] in_pc,
    input logic              in_switch_ok,
    input logic              lr_we,
    input logic [ADDR_W-1:0] lr_wdata,
    input logic              pc_we,
    input logic [ADDR_W-1:0] pc_wdata,
    input logic              state_clr
);
    AST_UPPER_ONLY_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b01) |=> (lr_we && !pc_we && !state_clr)); // R2

    AST_UPPER_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b01) |=> (lr_wdata[OFF_W:0] == $past(in_pc[OFF_W:0]))); // R2

    AST_KEEP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b10) |=> (lr_we && pc_we && !state_clr && !pc_wdata[0]
                                            && lr_wdata == $past(in_pc) - ADDR_W'(1))); // R3

    AST_SWITCH_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b11 && in_switch_ok) |=> (lr_we && pc_we && state_clr
                                                            && pc_wdata[1:0] == 2'b00)); // R4

    AST_SWITCH_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b11 && !in_switch_ok) |=> (!lr_we && !pc_we && !state_clr)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || in_kind == 2'b00) |=> (!lr_we && !pc_we && !state_clr)); // R7

    AST_PC_WITH_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we || state_clr) |-> lr_we); // R8
endmodule

bind lbs_seq lbs_seq_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/lbs_seq_test.sv
// Bench: vector table walked by one loop, then directed reset,
// two-part sequence and back-to-back tests.
module lbs_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int OW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_kind = 2'b00;
    logic [OW-1:0] in_field = '0;
    logic [AW-1:0] in_pc = '0;
    logic [AW-1:0] in_link = '0;
    logic          in_switch_ok = 1'b1;
    logic          lr_we;
    logic [AW-1:0] lr_wdata;
    logic          pc_we;
    logic [AW-1:0] pc_wdata;
    logic          state_clr;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lbs_seq #(.ADDR_W(AW), .OFF_W(OW)) uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_kind (in_kind),
        .in_field (in_field), .in_pc (in_pc), .in_link (in_link),
        .in_switch_ok (in_switch_ok), .lr_we (lr_we), .lr_wdata (lr_wdata),
        .pc_we (pc_we), .pc_wdata (pc_wdata), .state_clr (state_clr)
    );

    typedef struct packed {
        logic          v;
        logic [1:0]    k;
        logic          ok;
        logic [10:0]   f;
        logic [31:0]   pc;
        logic [31:0]   lk;
        logic          elw;
        logic [31:0]   elr;
        logic          epw;
        logic [31:0]   epc;
        logic          ec;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'b01, 1'b1, 11'h001, 32'h0000_0100, 32'h0, 1'b1, 32'h0000_1100, 1'b0, 32'h0, 1'b0}, // R2
        '{1'b1, 2'b01, 1'b1, 11'h7FF, 32'h0000_5000, 32'h0, 1'b1, 32'h0000_4000, 1'b0, 32'h0, 1'b0}, // R2 negative
        '{1'b1, 2'b01, 1'b0, 11'h400, 32'h0040_0000, 32'h0, 1'b1, 32'h0000_0000, 1'b0, 32'h0, 1'b0}, // R2 most negative
        '{1'b1, 2'b01, 1'b1, 11'h3FF, 32'h0000_0000, 32'h0, 1'b1, 32'h003F_F000, 1'b0, 32'h0, 1'b0}, // R2 most positive
        '{1'b1, 2'b10, 1'b1, 11'h7FF, 32'h0000_0300, 32'h0001_0000, 1'b1, 32'h0000_02FF, 1'b1, 32'h0001_1000, 1'b0}, // R6
        '{1'b1, 2'b10, 1'b1, 11'h000, 32'h0000_2000, 32'h0000_2001, 1'b1, 32'h0000_1FFF, 1'b1, 32'h0000_2002, 1'b0}, // R3
        '{1'b1, 2'b11, 1'b1, 11'h000, 32'h0000_2000, 32'h0000_2001, 1'b1, 32'h0000_1FFF, 1'b1, 32'h0000_2004, 1'b1}, // R4
        '{1'b1, 2'b11, 1'b1, 11'h001, 32'h0000_0400, 32'h0000_2001, 1'b1, 32'h0000_03FF, 1'b1, 32'h0000_2004, 1'b1}, // R4
        '{1'b1, 2'b11, 1'b0, 11'h001, 32'h0000_0400, 32'h0000_2001, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0}, // R5
        '{1'b1, 2'b10, 1'b0, 11'h001, 32'h0000_0010, 32'h0000_0020, 1'b1, 32'h0000_000F, 1'b1, 32'h0000_0024, 1'b0}, // R3 variant
        '{1'b1, 2'b00, 1'b1, 11'h123, 32'h0000_0500, 32'h0000_0600, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0}, // R7 kind none
        '{1'b0, 2'b01, 1'b1, 11'h123, 32'h0000_0500, 32'h0000_0600, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0}  // R7 not valid
    };

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request on the current falling edge.
    task automatic drive(input logic v, input logic [1:0] k, input logic ok,
                         input logic [10:0] f, input logic [31:0] pc, input logic [31:0] lk);
        in_valid = v; in_kind = k; in_switch_ok = ok;
        in_field = f; in_pc = pc; in_link = lk;
    endtask

    // Check all outputs against one expected set; data only when enabled.
    task automatic chk_all(input string req, input logic elw, input logic [31:0] elr,
                           input logic epw, input logic [31:0] epc, input logic ec);
        chk({req, " lr_we"}, 32'(lr_we), 32'(elw));
        chk({req, " pc_we"}, 32'(pc_we), 32'(epw));
        chk({req, " state_clr"}, 32'(state_clr), 32'(ec));
        if (elw) chk({req, " lr_wdata"}, lr_wdata, elr);
        if (epw) chk({req, " pc_wdata"}, pc_wdata, epc);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        logic [31:0] parked;
        // R1: reset with a request pending
        drive(1'b1, 2'b11, 1'b1, 11'h7FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        chk_all("R1 reset", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
        chk("R1 lr_wdata zero", lr_wdata, 32'h0);
        chk("R1 pc_wdata zero", pc_wdata, 32'h0);
        drive(1'b0, 2'b00, 1'b1, 11'h0, 32'h0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table; each result is read one edge after its request (R8)
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].v, VECS[i].k, VECS[i].ok, VECS[i].f, VECS[i].pc, VECS[i].lk);
            @(negedge clk);
            chk_all($sformatf("R8 vec%0d", i), VECS[i].elw, VECS[i].elr,
                    VECS[i].epw, VECS[i].epc, VECS[i].ec);
        end

        // R8: one-cycle pulse, quiet after the request is withdrawn
        drive(1'b1, 2'b11, 1'b1, 11'h0, 32'h100, 32'h200);
        @(negedge clk);
        drive(1'b0, 2'b11, 1'b1, 11'h0, 32'h100, 32'h200);
        @(negedge clk);
        chk_all("R8 pulse end", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);

        // Forward reach limit, keep form: R2 then R3
        drive(1'b1, 2'b01, 1'b1, 11'h3FF, 32'h0800_0000, 32'h0);
        @(negedge clk);
        parked = lr_wdata;
        chk("R2 fwd parked", parked, 32'h083F_F000);
        drive(1'b1, 2'b10, 1'b1, 11'h7FF, 32'h0800_0002, parked);
        @(negedge clk);
        chk_all("R3 fwd keep", 1'b1, 32'h0800_0001, 1'b1, 32'h0840_0000, 1'b0);

        // Forward reach limit, switch form: R4
        drive(1'b1, 2'b01, 1'b1, 11'h3FF, 32'h0800_0000, 32'h0);
        @(negedge clk);
        parked = lr_wdata;
        drive(1'b1, 2'b11, 1'b1, 11'h7FF, 32'h0800_0002, parked);
        @(negedge clk);
        chk_all("R4 fwd switch", 1'b1, 32'h0800_0001, 1'b1, 32'h0840_0000, 1'b1);

        // Backward reach limit, both forms
        drive(1'b1, 2'b01, 1'b1, 11'h400, 32'h0800_0000, 32'h0);
        @(negedge clk);
        parked = lr_wdata;
        chk("R2 back parked", parked, 32'h07C0_0000);
        drive(1'b1, 2'b10, 1'b1, 11'h000, 32'h0800_0002, parked);
        @(negedge clk);
        chk_all("R3 back keep", 1'b1, 32'h0800_0001, 1'b1, 32'h07C0_0002, 1'b0);
        drive(1'b1, 2'b11, 1'b1, 11'h000, 32'h0800_0002, parked);
        @(negedge clk);
        chk_all("R4 back switch", 1'b1, 32'h0800_0001, 1'b1, 32'h07C0_0004, 1'b1);

        // R6: target from incoming link, wrapping through zero
        drive(1'b1, 2'b01, 1'b1, 11'h7FF, 32'h0000_1000, 32'h0);
        @(negedge clk);
        parked = lr_wdata;
        drive(1'b1, 2'b10, 1'b1, 11'h001, 32'h0000_1002, parked);
        @(negedge clk);
        chk_all("R6 wrap keep", 1'b1, 32'h0000_1001, 1'b1, 32'h0000_0004, 1'b0);

        // R5 then R4 back to back, variant flag toggled
        drive(1'b1, 2'b11, 1'b0, 11'h010, 32'h0000_3000, 32'h0000_4000);
        @(negedge clk);
        chk_all("R5 blocked", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
        drive(1'b1, 2'b11, 1'b1, 11'h010, 32'h0000_3000, 32'h0000_4000);
        @(negedge clk);
        chk_all("R4 after block", 1'b1, 32'h0000_2FFF, 1'b1, 32'h0000_4024, 1'b1);

        // R1: reset in mid-stream clears a pending result
        drive(1'b1, 2'b01, 1'b1, 11'h001, 32'h0, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        chk_all("R1 mid reset", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
        rst_n = 1'b1;
        drive(1'b0, 2'b00, 1'b1, 11'h0, 32'h0, 32'h0);
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule